// File: doc/BRIEF.md
# Interleaved Chroma Horizontal Edge-Offset Filter

This block filters one block of 8-bit chroma in which the two components alternate byte by byte (first component on even bytes, second on odd bytes). It works one row at a time. Each sample is compared with the nearest sample of the same component on its left and on its right, which lie two bytes away. The result of the two comparisons selects an edge category. The category goes through a programmable remap table and then selects a signed offset from the table of that component. The offset is added to the sample, and the sum is clipped to 0..255.

A start pulse captures the block geometry, the left/right availability flags, the remap table, both offset tables and the last pair of the current top context. Pixels then arrive on a valid/ready byte stream. Each row carries W+4 bytes: the saved left pair for that row, the W bytes of the block, and the two bytes just beyond its right edge. Filtered bytes leave on a second valid/ready stream.

The block also reports context updates through write-strobe ports:
- the unfiltered last pair of every row, for the left-column buffer;
- the unfiltered bottom row, for the top buffer;
- the saved top pair, for the top-left context.

A done pulse follows the last row. W is a multiple of 8 and at least 8. H is at least 1. A width that is not a multiple of 16 needs no special handling, because the datapath works one byte at a time.

Top module: `sao_chroma_hfilt`

## Requirements
- R1: For output byte x of a row (stream position x+2), the left and right neighbours are the bytes at stream positions x and x+4.
  - Each side sign is +1 if the centre is greater than the neighbour, -1 if it is smaller, and 0 if they are equal.
  - The raw category is 2 + left sign + right sign, a value from 0 to 4.
  - The raw category is remapped through `edgeMap`, whose entry i sits at bits [3i+2:3i].
- R2: An even x takes its offset from `offTblU` and an odd x from `offTblV`. Entry k of each table is a signed byte at bits [8k+7:8k], indexed by the remapped category. A remapped category above 4 gives offset 0.
- R3: The output byte is the sample plus the sign-extended offset, clipped to the range 0..255.
- R4: When `availLeft` is 0, the category of x=0 and x=1 is forced to 0. When `availRight` is 0, the category of x=W-2 and x=W-1 is forced to 0. A forced category still selects table entry 0. Interior bytes are never forced.
- R5: Each row takes W+4 input bytes and produces W output bytes in order. Output byte x becomes valid in the cycle after the input byte at position x+4 is accepted.
- R6: Once `outValid` is raised, it and `outData` hold until `outReady` is seen. `inReady` is low while a held output is not being taken, and low whenever no block is in progress.
- R7: In the cycle after input position W+1 of row r is accepted, `leftWrEn` pulses with `leftWrRow`=r. `leftWrData` carries position W in [7:0] and position W+1 in [15:8], both unfiltered.
- R8: During the last row, every output byte x is accompanied by `topWrEn` with `topWrIdx`=x and `topWrData` set to the unfiltered sample.
- R9: In the cycle after a start is accepted, `topLeftWrEn` pulses with `topLeftWrData` equal to `topLastPair`.
- R10:
  - `done` pulses for one cycle in the cycle after the last input byte of the last row is accepted.
  - A start pulse while a block is in progress is ignored: it causes no `topLeftWrEn`.
- R11: During reset, `outValid`, `inReady`, `done` and all write strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block; captures configuration |
| cfgWidth | input | $clog2(MAX_W+1) | Block width W in bytes |
| cfgHeight | input | $clog2(MAX_H+1) | Block height H in rows |
| availLeft | input | 1 | Left neighbour block available |
| availRight | input | 1 | Right neighbour block available |
| edgeMap | input | 15 | Category remap, 5 entries of 3 bits |
| offTblU | input | 40 | Even-byte offsets, 5 signed bytes |
| offTblV | input | 40 | Odd-byte offsets, 5 signed bytes |
| topLastPair | input | 16 | Last pair of the current top buffer |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inReady | output | 1 | Input byte accepted when high with inValid |
| outValid | output | 1 | Filtered byte valid |
| outData | output | 8 | Filtered byte |
| outReady | input | 1 | Consumer takes the filtered byte |
| leftWrEn | output | 1 | Left-column buffer write strobe |
| leftWrRow | output | $clog2(MAX_H+1) | Row written in the left-column buffer |
| leftWrData | output | 16 | Unfiltered last pair of that row |
| topWrEn | output | 1 | Top buffer write strobe |
| topWrIdx | output | $clog2(MAX_W) | Byte index in the top buffer |
| topWrData | output | 8 | Unfiltered bottom-row byte |
| topLeftWrEn | output | 1 | Top-left context write strobe |
| topLeftWrData | output | 16 | New top-left pair |
| done | output | 1 | Block finished pulse |

## Verification
The results fall due at fixed distances from the handshake that causes them:
- a filtered byte, together with its top-buffer write, is valid one cycle after the input byte at position x+4 is accepted;
- the left-column write comes one cycle after position W+1 is accepted;
- the top-left write comes one cycle after the start is accepted;
- `done` comes one cycle after the final byte is accepted.

The bench drives its inputs just after the rising edge and samples every output at the falling edge. It counts an output only when `outValid` and `outReady` are both high at that falling edge, and it checks every strobe on the single falling edge on which it is high. Held outputs are compared across consecutive falling edges while `outReady` stays low, so the bench also sees that a held byte does not change before it is taken.

// File: rtl/sao_chroma_pkg.sv
package sao_chroma_pkg;
  // Per-beat strobes from control to datapath
  typedef struct packed {
    logic load;     // start accepted: capture tables
    logic shift;    // input byte accepted
    logic emit;     // a filtered byte is produced this beat
    logic isOdd;    // produced byte is second component
    logic maskCat;  // force category to zero (edge unavailable)
    logic topWr;    // produced byte belongs to the last row
    logic leftCap;  // capture last pair for the left column
  } saoStrobe_t;
endpackage

// File: rtl/sao_chroma_ctrl.sv
module sao_chroma_ctrl
  import sao_chroma_pkg::*;
#(
  parameter int MAX_W = 256,
  parameter int MAX_H = 64,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int PW = $clog2(MAX_W + 4),
  localparam int HW = $clog2(MAX_H + 1),
  localparam int XW = $clog2(MAX_W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [WW-1:0] cfgWidth,
  input  logic [HW-1:0] cfgHeight,
  input  logic          availLeft,
  input  logic          availRight,
  input  logic          inValid,
  input  logic          outValid,
  input  logic          outReady,
  output logic          inReady,
  output saoStrobe_t    strb,
  output logic [XW-1:0] xIdx,
  output logic [HW-1:0] rowIdx,
  output logic          done
);
  logic          busy, aL, aR;
  logic [PW-1:0] wdt, pos;
  logic [HW-1:0] hgt, row;
  logic          acc, lastPosHit, lastRow, lastBeat;

  assign inReady    = busy && (!outValid || outReady);
  assign acc        = inValid && inReady;
  assign lastPosHit = (pos == wdt + PW'(3));
  assign lastRow    = (row == hgt - HW'(1));
  assign lastBeat   = acc && lastPosHit && lastRow;
  assign xIdx       = XW'(pos - PW'(4));
  assign rowIdx     = row;

  always_comb begin
    strb.load    = start && !busy;
    strb.shift   = acc;
    strb.emit    = acc && (pos >= PW'(4));
    strb.isOdd   = pos[0];
    // first pair: positions 4,5; last pair: positions W+2, W+3 (R4)
    strb.maskCat = ((pos < PW'(6)) && !aL) || ((pos >= wdt + PW'(2)) && !aR);
    strb.topWr   = acc && (pos >= PW'(4)) && lastRow;
    strb.leftCap = acc && (pos == wdt + PW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      aL   <= 1'b0;
      aR   <= 1'b0;
      wdt  <= '0;
      hgt  <= '0;
      pos  <= '0;
      row  <= '0;
      done <= 1'b0;
    end else begin
      done <= lastBeat;
      if (start && !busy) begin
        busy <= 1'b1;
        wdt  <= PW'(cfgWidth);
        hgt  <= cfgHeight;
        aL   <= availLeft;
        aR   <= availRight;
        pos  <= '0;
        row  <= '0;
      end else if (acc) begin
        if (lastPosHit) begin
          pos <= '0;
          row <= row + HW'(1);
          if (lastRow) busy <= 1'b0;
        end else begin
          pos <= pos + PW'(1);
        end
      end
    end
  end

  // R6: no input is taken while no block is in progress
  a_r6_idle_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !inReady);
  // R10: done lasts a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/sao_chroma_dp.sv
module sao_chroma_dp
  import sao_chroma_pkg::*;
#(
  parameter int MAX_W = 256,
  parameter int MAX_H = 64,
  localparam int HW = $clog2(MAX_H + 1),
  localparam int XW = $clog2(MAX_W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  saoStrobe_t    strb,
  input  logic [7:0]    inData,
  input  logic [14:0]   edgeMap,
  input  logic [39:0]   offTblU,
  input  logic [39:0]   offTblV,
  input  logic [15:0]   topLastPair,
  input  logic [XW-1:0] xIdx,
  input  logic [HW-1:0] rowIdx,
  input  logic          outReady,
  output logic          outValid,
  output logic [7:0]    outData,
  output logic          leftWrEn,
  output logic [HW-1:0] leftWrRow,
  output logic [15:0]   leftWrData,
  output logic          topWrEn,
  output logic [XW-1:0] topWrIdx,
  output logic [7:0]    topWrData,
  output logic          topLeftWrEn,
  output logic [15:0]   topLeftWrData
);
  logic [14:0] mapR;
  logic [39:0] tblUR, tblVR;
  logic [7:0]  win [4];   // win[0] newest, win[1] centre, win[3] left neighbour
  logic [7:0]  cen, lft, rgt;
  logic [2:0]  rawCat, mapCat, cat;
  logic [39:0] selTbl;
  logic [7:0]  off;
  logic [9:0]  sum;
  logic [7:0]  clipped;

  assign cen = win[1];
  assign lft = win[3];
  assign rgt = inData;

  // R1: two-sided comparison with same-component neighbours
  always_comb begin
    rawCat = 3'd2 + {2'b00, cen > lft} + {2'b00, cen > rgt}
                  - {2'b00, cen < lft} - {2'b00, cen < rgt};
    mapCat = mapR[int'(rawCat) * 3 +: 3];
    cat    = strb.maskCat ? 3'd0 : mapCat;          // R4
    selTbl = strb.isOdd ? tblVR : tblUR;            // R2
    off    = (cat > 3'd4) ? 8'd0 : selTbl[int'(cat) * 8 +: 8];
    sum    = {2'b00, cen} + {{2{off[7]}}, off};
    // R3: saturate to 0..255
    if (sum[9])      clipped = 8'd0;
    else if (sum[8]) clipped = 8'd255;
    else             clipped = sum[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mapR          <= '0;
      tblUR         <= '0;
      tblVR         <= '0;
      for (int i = 0; i < 4; i++) win[i] <= '0;
      outValid      <= 1'b0;
      outData       <= '0;
      leftWrEn      <= 1'b0;
      leftWrRow     <= '0;
      leftWrData    <= '0;
      topWrEn       <= 1'b0;
      topWrIdx      <= '0;
      topWrData     <= '0;
      topLeftWrEn   <= 1'b0;
      topLeftWrData <= '0;
    end else begin
      topLeftWrEn <= strb.load;                     // R9
      if (strb.load) begin
        mapR          <= edgeMap;
        tblUR         <= offTblU;
        tblVR         <= offTblV;
        topLeftWrData <= topLastPair;
      end
      if (strb.shift) begin
        win[3] <= win[2];
        win[2] <= win[1];
        win[1] <= win[0];
        win[0] <= inData;
      end
      if (strb.emit) begin                          // R5
        outValid <= 1'b1;
        outData  <= clipped;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
      topWrEn  <= strb.topWr;                       // R8
      if (strb.topWr) begin
        topWrIdx  <= xIdx;
        topWrData <= cen;
      end
      leftWrEn <= strb.leftCap;                     // R7
      if (strb.leftCap) begin
        leftWrRow  <= rowIdx;
        leftWrData <= {inData, win[0]};
      end
    end
  end

  // R6: a held output stays put until taken
  a_r6_hold_output: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
  // R7: left capture coincides with a produced byte
  a_r7_left_with_out: assert property (@(posedge clk) disable iff (!rstN)
    leftWrEn |-> outValid);
  // R8: top write coincides with a produced byte
  a_r8_top_with_out: assert property (@(posedge clk) disable iff (!rstN)
    topWrEn |-> outValid);
  // R9: top-left write only right after an accepted start
  a_r9_topleft_after_load: assert property (@(posedge clk) disable iff (!rstN)
    topLeftWrEn |-> $past(strb.load));
endmodule

// File: rtl/sao_chroma_hfilt.sv
module sao_chroma_hfilt
  import sao_chroma_pkg::*;
#(
  parameter int MAX_W = 256,
  parameter int MAX_H = 64,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1),
  localparam int XW = $clog2(MAX_W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [WW-1:0] cfgWidth,
  input  logic [HW-1:0] cfgHeight,
  input  logic          availLeft,
  input  logic          availRight,
  input  logic [14:0]   edgeMap,
  input  logic [39:0]   offTblU,
  input  logic [39:0]   offTblV,
  input  logic [15:0]   topLastPair,
  input  logic          inValid,
  input  logic [7:0]    inData,
  output logic          inReady,
  output logic          outValid,
  output logic [7:0]    outData,
  input  logic          outReady,
  output logic          leftWrEn,
  output logic [HW-1:0] leftWrRow,
  output logic [15:0]   leftWrData,
  output logic          topWrEn,
  output logic [XW-1:0] topWrIdx,
  output logic [7:0]    topWrData,
  output logic          topLeftWrEn,
  output logic [15:0]   topLeftWrData,
  output logic          done
);
  saoStrobe_t    strb;
  logic [XW-1:0] xIdx;
  logic [HW-1:0] rowIdx;

  sao_chroma_ctrl #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgWidth(cfgWidth),
    .cfgHeight(cfgHeight), .availLeft(availLeft), .availRight(availRight),
    .inValid(inValid), .outValid(outValid), .outReady(outReady),
    .inReady(inReady), .strb(strb), .xIdx(xIdx), .rowIdx(rowIdx), .done(done)
  );

  sao_chroma_dp #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData), .edgeMap(edgeMap),
    .offTblU(offTblU), .offTblV(offTblV), .topLastPair(topLastPair),
    .xIdx(xIdx), .rowIdx(rowIdx), .outReady(outReady),
    .outValid(outValid), .outData(outData),
    .leftWrEn(leftWrEn), .leftWrRow(leftWrRow), .leftWrData(leftWrData),
    .topWrEn(topWrEn), .topWrIdx(topWrIdx), .topWrData(topWrData),
    .topLeftWrEn(topLeftWrEn), .topLeftWrData(topLeftWrData)
  );
endmodule

// File: tb/test_sao_chroma_hfilt.sv
module test_sao_chroma_hfilt;
  localparam int MAX_W = 256;
  localparam int MAX_H = 64;
  localparam int WW = $clog2(MAX_W + 1);
  localparam int HW = $clog2(MAX_H + 1);
  localparam int XW = $clog2(MAX_W);

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [WW-1:0] cfgWidth = '0;
  logic [HW-1:0] cfgHeight = '0;
  logic availLeft = 1'b1, availRight = 1'b1;
  logic [14:0] edgeMap = '0;
  logic [39:0] offTblU = '0, offTblV = '0;
  logic [15:0] topLastPair = '0;
  logic inValid = 1'b0, outReady = 1'b1;
  logic [7:0] inData = '0;
  logic inReady, outValid, leftWrEn, topWrEn, topLeftWrEn, done;
  logic [7:0] outData, topWrData;
  logic [HW-1:0] leftWrRow;
  logic [15:0] leftWrData, topLeftWrData;
  logic [XW-1:0] topWrIdx;

  sao_chroma_hfilt #(.MAX_W(MAX_W), .MAX_H(MAX_H)) i_sao_chroma_hfilt (.*);

  always #4 clk = ~clk;   // 125 MHz

  // bench state
  int nChk = 0, nErr = 0;
  bit finished = 0;
  int W, H;
  bit aL, aR, fullReady = 1;
  logic [7:0] pix [0:3][0:51];
  int outCnt, leftCnt, topCnt, tlCnt, doneCnt;
  bit prevStall;
  logic [7:0] prevData;

  task automatic chk(bit ok, string tag, int act, int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sgn(int a, int b);
    return (a > b) ? 1 : ((a < b) ? -1 : 0);
  endfunction

  function automatic int expByte(int r, int x);
    int c, raw, m, off, v;
    logic [7:0] ob;
    c   = pix[r][x+2];
    raw = 2 + sgn(c, pix[r][x]) + sgn(c, pix[r][x+4]);
    m   = int'((edgeMap >> (3 * raw)) & 15'h7);
    if ((x < 2 && !aL) || (x >= W - 2 && !aR)) m = 0;
    if (m > 4) off = 0;
    else begin
      ob  = (x % 2 == 0) ? offTblU[8*m +: 8] : offTblV[8*m +: 8];
      off = int'($signed(ob));
    end
    v = c + off;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  // monitor: all sampling at the falling edge
  always @(negedge clk) if (rstN) begin
    if (prevStall)
      chk(outValid && outData == prevData, "R6 held output", int'(outData), int'(prevData));
    prevStall = outValid && !outReady;
    prevData  = outData;
    if (outValid && outReady) begin
      chk(int'(outData) == expByte(outCnt / W, outCnt % W),
          "R1/R2/R3/R4/R5 filtered byte", int'(outData), expByte(outCnt / W, outCnt % W));
      outCnt++;
    end
    if (leftWrEn) begin
      chk(int'(leftWrRow) == leftCnt, "R7 left row", int'(leftWrRow), leftCnt);
      chk(leftWrData == {pix[leftCnt][W+1], pix[leftCnt][W]}, "R7 left pair",
          int'(leftWrData), int'({pix[leftCnt][W+1], pix[leftCnt][W]}));
      leftCnt++;
    end
    if (topWrEn) begin
      chk(int'(topWrIdx) == topCnt, "R8 top index", int'(topWrIdx), topCnt);
      chk(topWrData == pix[H-1][topCnt+2], "R8 top data", int'(topWrData),
          int'(pix[H-1][topCnt+2]));
      topCnt++;
    end
    if (topLeftWrEn) begin
      chk(topLeftWrData == 16'hA55A, "R9 top-left pair", int'(topLeftWrData), 16'hA55A);
      tlCnt++;
    end
    if (done) doneCnt++;
  end

  always @(posedge clk) begin
    #1 outReady = fullReady ? 1'b1 : (($urandom % 4) != 0);
  end

  task automatic pulseStart(logic [15:0] tp);
    topLastPair = tp;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic streamAll();
    bit ok;
    for (int r = 0; r < H; r++)
      for (int p = 0; p < W + 4; p++) begin
        if (!fullReady && ($urandom % 3 == 0)) begin
          inValid = 1'b0;
          @(posedge clk); #1;
        end
        inValid = 1'b1;
        inData  = pix[r][p];
        do begin
          @(negedge clk); ok = inReady;
          @(posedge clk); #1;
        end while (!ok);
      end
    inValid = 1'b0;
  endtask

  task automatic runTest(int w, int h, bit midStart);
    W = w; H = h;
    cfgWidth  = WW'(w);
    cfgHeight = HW'(h);
    availLeft = aL; availRight = aR;
    outCnt = 0; leftCnt = 0; topCnt = 0; tlCnt = 0; doneCnt = 0;
    @(posedge clk); #1;
    pulseStart(16'hA55A);
    fork
      streamAll();
      begin
        if (midStart) begin
          repeat (6) @(posedge clk);
          #2 start = 1'b1;
          @(posedge clk); #1 start = 1'b0;
        end
      end
    join
    repeat (30) @(posedge clk);
    chk(outCnt == W * H, "R5 output count", outCnt, W * H);
    chk(leftCnt == H, "R7 left write count", leftCnt, H);
    chk(topCnt == W, "R8 top write count", topCnt, W);
    chk(tlCnt == 1, "R9/R10 top-left count (busy start ignored)", tlCnt, 1);
    chk(doneCnt == 1, "R10 done count", doneCnt, 1);
  endtask

  function automatic logic [14:0] packMap(int a, int b, int c, int d, int e);
    return {3'(e), 3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  initial begin
    void'($urandom(32'd11));
    repeat (3) begin
      @(negedge clk);
      chk(!outValid && !inReady && !done && !leftWrEn && !topWrEn && !topLeftWrEn,
          "R11 reset state", int'({outValid, inReady, done, leftWrEn, topWrEn, topLeftWrEn}), 0);
    end
    @(posedge clk); #1 rstN = 1'b1;

    // R1: identity remap, small values to get ties
    aL = 1; aR = 1;
    edgeMap = packMap(0, 1, 2, 3, 4);
    offTblU = {8'd40, 8'd30, 8'd20, 8'd10, 8'd5};
    offTblV = {8'hF6, 8'hEC, 8'd3, 8'd7, 8'd9};
    for (int r = 0; r < 4; r++) for (int p = 0; p < 52; p++) pix[r][p] = 8'(100 + $urandom % 4);
    runTest(16, 2, 0);

    // R4: both edges unavailable, residue width 8, nonzero entry 0
    aL = 0; aR = 0;
    edgeMap = packMap(1, 2, 0, 3, 4);
    offTblU = {8'd4, 8'd3, 8'd2, 8'd1, 8'd50};
    offTblV = {8'd4, 8'd3, 8'd2, 8'd1, 8'hC0};
    for (int r = 0; r < 4; r++) for (int p = 0; p < 52; p++) pix[r][p] = 8'($urandom % 256);
    runTest(8, 3, 0);

    // R3: saturation both ways
    aL = 1; aR = 1;
    edgeMap = packMap(0, 1, 2, 3, 4);
    offTblU = {5{8'h7F}};
    offTblV = {5{8'h80}};
    for (int p = 0; p < 52; p++) pix[0][p] = (p % 2 == 0) ? 8'(240 + $urandom % 16) : 8'($urandom % 20);
    runTest(16, 1, 0);

    // R1/R2: flat rows (category 2), remap entry above 4 gives zero offset
    edgeMap = packMap(0, 1, 7, 3, 4);
    offTblU = {8'd1, 8'd2, 8'd3, 8'd4, 8'd5};
    offTblV = offTblU;
    for (int r = 0; r < 4; r++) for (int p = 0; p < 52; p++) pix[r][p] = 8'd77;
    runTest(24, 2, 0);

    // random mix with back-pressure and ignored mid-block starts (R6, R10)
    fullReady = 0;
    for (int t = 0; t < 10; t++) begin
      aL = 1'($urandom); aR = 1'($urandom);
      edgeMap = packMap($urandom % 5, $urandom % 5, $urandom % 5, $urandom % 5, $urandom % 5);
      offTblU = {$urandom, $urandom} ;
      offTblV = {$urandom, $urandom};
      for (int r = 0; r < 4; r++) for (int p = 0; p < 52; p++)
        pix[r][p] = (t % 2 == 0) ? 8'($urandom % 256) : 8'(128 + $urandom % 3);
      runTest(8 * (1 + int'($urandom % 6)), 1 + int'($urandom % 4), t % 3 == 0);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nErr++; nChk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end
endmodule